// File: doc/BRIEF.md
# Register-Mapped Stream FIFO

This block is a synchronous first-in first-out buffer between bus firmware and a streaming core. One build parameter picks the direction. In the transmit build, a bus write to the data register adds a word, and the core removes words with a pop strobe. In the receive build, the core adds words with a push strobe, and a bus read of the data register returns the oldest word and removes it. The depth is 2^AW words of DW bits each. Both sides share one clock.

Next to the data register there are three companion registers in a small window at base 0xFE00. A read-only fill count is at 0xFE04. A writable threshold is at 0xFE08, and a threshold flag goes high while the fill count is greater than it. A flush command is at 0xFE0C: writing any value to it empties the buffer, and it needs no clear from firmware. The bus side is a plain register port. A write completes on the clock edge where `reg_sel` and `reg_wr` are both high. A read returns `reg_rdata` combinationally while `reg_sel` is high and `reg_wr` is low. A read of the data register in the receive build pops one word at that edge.

A three-state fill machine tracks occupancy. Its states are EMPTY, PARTIAL and FULL, and its transitions are:
- fill: EMPTY to PARTIAL on an accepted push.
- top-off: PARTIAL to FULL on a lone push when one slot is left.
- drain: PARTIAL to EMPTY on a lone pop when one word is left.
- release: FULL to PARTIAL on an accepted pop.
- flush: any state to EMPTY.

A push and a pop in the same cycle leave the state unchanged.

Top module: `bus_fifo_port`

## Requirements
- R1: After reset the fill count is 0, `fifo_empty` is 1, `fifo_full` is 0, `thr_flag` is 0 and the threshold reads 0.
- R2: Transmit build: a bus write to 0xFE00 stores `reg_wdata[DW-1:0]`. `core_rdata` shows the oldest word, and `core_pop` removes it. Words come out in the order they were written.
- R3: Receive build: `core_push` stores `core_wdata`. A bus read of 0xFE00 returns the oldest word in `reg_rdata[DW-1:0]` with the upper bits at zero, and removes that word at the same edge.
- R4: Reading 0xFE04 returns the fill count, zero-extended. `fifo_level` carries the same value. The count is AW+1 bits wide and ranges from 0 to 2^AW.
- R5: A push while FULL is dropped. The count stays at 2^AW and the stored words are unchanged. This also applies when a pop happens in the same cycle; the pop is still performed.
- R6: A pop while EMPTY leaves the count at 0. The data output keeps the last word removed, or 0 if no word has been removed since reset.
- R7: A write to 0xFE08 loads the threshold from `reg_wdata[AW:0]`, and a read returns it. `thr_flag` equals (count > threshold). It changes on the same edge as the count or the threshold.
- R8: A write of any value to 0xFE0C empties the buffer at that edge and overrides a push or pop in the same cycle. The register reads 0. Words pushed afterwards come out in order.
- R9: A push and a pop in the same cycle while PARTIAL leave the count unchanged and keep the order.
- R10: Transmit build: `core_push` has no effect, and a bus read of 0xFE00 does not pop but returns the last bus-written word, zero-extended. Receive build: `core_pop` and bus writes to 0xFE00 have no effect.
- R11: `fifo_empty` is high exactly when the count is 0, and `fifo_full` is high exactly when the count is 2^AW. The two are never high together.
- R12: Addresses outside the four registers read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| core_push | input | 1 | Core push strobe (receive build) |
| core_wdata | input | DW | Core push data |
| core_pop | input | 1 | Core pop strobe (transmit build) |
| core_rdata | output | DW | Oldest word (transmit build), 0 in the receive build |
| fifo_level | output | AW+1 | Fill count |
| fifo_full | output | 1 | Count equals 2^AW |
| fifo_empty | output | 1 | Count equals 0 |
| thr_flag | output | 1 | Count greater than threshold |

## Verification
A fill state that disagrees with the pointers shows up one edge later. Either a word is dropped or repeated on the data output, or `fifo_full`/`fifo_empty` disagree with `fifo_level`. A counter that slips shows on `fifo_level` and the level register on the next edge. A stale threshold compare shows on `thr_flag` at the same edge as the change that should have moved it. The scoreboard compares every popped word against the written order, so a pointer fault is caught at the first pop that passes the faulty slot.

// File: rtl/fifo_port_pkg.sv
`timescale 1ns/1ps
package fifo_port_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

    // word index inside the register window, from address bits [3:2]
    typedef enum logic [1:0] {
        RI_DATA   = 2'd0,
        RI_LEVEL  = 2'd1,
        RI_THRESH = 2'd2,
        RI_FLUSH  = 2'd3
    } reg_idx_t;

endpackage

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          flush,
    input  logic          is_empty,
    output logic [DW-1:0] head_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [DW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wr_ptr <= '0;
        else if (flush)  wr_ptr <= '0;
        else if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (flush)  rd_ptr <= '0;
        else if (rd_en)  rd_ptr <= rd_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // last word removed, shown while nothing is stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_q <= '0;
        else if (rd_en)  last_q <= mem[rd_ptr];
    end

    assign head_data = is_empty ? last_q : mem[rd_ptr];

endmodule

// File: rtl/fifo_fill_fsm.sv
`timescale 1ns/1ps
module fifo_fill_fsm
    import fifo_port_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_req,
    input  logic        pop_req,
    input  logic        flush,
    input  logic [AW:0] thr_nxt,
    output logic        push_ok,
    output logic        pop_ok,
    output logic [AW:0] level,
    output logic        full,
    output logic        empty,
    output logic        thr_flag
);
    localparam logic [AW:0] LVL_ONE    = {{AW{1'b0}}, 1'b1};
    localparam logic [AW:0] LVL_ALMOST = {1'b0, {AW{1'b1}}};

    fill_state_t state_q, state_d;
    logic [AW:0] level_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (push_ok) state_d = ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (push_ok && !pop_ok && level == LVL_ALMOST)
                        state_d = ST_FULL;
                    else if (pop_ok && !push_ok && level == LVL_ONE)
                        state_d = ST_EMPTY;
                end
                ST_FULL: begin
                    if (pop_ok) state_d = ST_PARTIAL;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        full    = 1'b0;
        empty   = 1'b0;
        unique case (state_q)
            ST_EMPTY:   empty = 1'b1;
            ST_PARTIAL: ;
            ST_FULL:    full  = 1'b1;
            default:    empty = 1'b1;
        endcase
        push_ok = push_req && !flush && !full;
        pop_ok  = pop_req  && !flush && !empty;
    end

    always_comb begin
        if (flush) begin
            level_d = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   level_d = level + LVL_ONE;
                2'b01:   level_d = level - LVL_ONE;
                default: level_d = level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level    <= '0;
            thr_flag <= 1'b0;
        end else begin
            level    <= level_d;
            thr_flag <= (level_d > thr_nxt);
        end
    end

endmodule

// File: rtl/fifo_regdec.sv
`timescale 1ns/1ps
module fifo_regdec
    import fifo_port_pkg::*;
#(
    parameter int          AW        = 4,
    parameter int          DW        = 8,
    parameter int          BUS_DW    = 32,
    parameter bit          IS_RX     = 1'b0,
    parameter logic [15:0] BASE_ADDR = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [15:0]       reg_addr,
    input  logic [BUS_DW-1:0] reg_wdata,
    input  logic [AW:0]       level,
    input  logic [DW-1:0]     head_data,
    output logic [BUS_DW-1:0] reg_rdata,
    output logic              data_wr,
    output logic              data_rd,
    output logic              flush_req,
    output logic [AW:0]       thr_q,
    output logic [AW:0]       thr_nxt
);
    logic     hit;
    reg_idx_t idx;
    logic     thr_wr;
    logic [DW-1:0] data_view;

    assign hit = reg_sel && (reg_addr[15:4] == BASE_ADDR[15:4])
                         && (reg_addr[1:0] == 2'b00);
    assign idx = reg_idx_t'(reg_addr[3:2]);

    assign data_wr   = hit &&  reg_wr && (idx == RI_DATA);
    assign data_rd   = hit && !reg_wr && (idx == RI_DATA);
    assign thr_wr    = hit &&  reg_wr && (idx == RI_THRESH);
    assign flush_req = hit &&  reg_wr && (idx == RI_FLUSH);

    assign thr_nxt = thr_wr ? reg_wdata[AW:0] : thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= '0;
        else        thr_q <= thr_nxt;
    end

    generate
        if (IS_RX) begin : g_rx_view
            logic unused_wdata;
            assign unused_wdata = ^reg_wdata;
            assign data_view    = head_data;
        end else begin : g_tx_view
            logic [DW-1:0] last_wr_q;
            logic          unused_head;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       last_wr_q <= '0;
                else if (data_wr) last_wr_q <= reg_wdata[DW-1:0];
            end
            assign unused_head = ^{head_data, reg_wdata};
            assign data_view   = last_wr_q;
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (hit && !reg_wr) begin
            unique case (idx)
                RI_DATA:   reg_rdata[DW-1:0] = data_view;
                RI_LEVEL:  reg_rdata[AW:0]   = level;
                RI_THRESH: reg_rdata[AW:0]   = thr_q;
                RI_FLUSH:  reg_rdata         = '0;
                default:   reg_rdata         = '0;
            endcase
        end
    end

endmodule

// File: rtl/bus_fifo_port.sv
`timescale 1ns/1ps
module bus_fifo_port #(
    parameter int          AW        = 4,
    parameter int          DW        = 8,
    parameter bit          IS_RX     = 1'b0,
    parameter logic [15:0] BASE_ADDR = 16'hFE00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [15:0]   reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          core_push,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_pop,
    output logic [DW-1:0] core_rdata,
    output logic [AW:0]   fifo_level,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic          thr_flag
);
    localparam int BUS_DW = 32;

    logic          data_wr, data_rd, flush_req;
    logic [AW:0]   thr_q, thr_nxt;
    logic          push_req, pop_req, push_ok, pop_ok;
    logic [DW-1:0] push_data, head_data;

    fifo_regdec #(
        .AW(AW), .DW(DW), .BUS_DW(BUS_DW), .IS_RX(IS_RX), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .level(fifo_level), .head_data(head_data),
        .reg_rdata(reg_rdata), .data_wr(data_wr), .data_rd(data_rd),
        .flush_req(flush_req), .thr_q(thr_q), .thr_nxt(thr_nxt)
    );

    generate
        if (IS_RX) begin : g_rx
            logic unused_rx;
            assign unused_rx  = ^{core_pop, data_wr};
            assign push_req   = core_push;
            assign push_data  = core_wdata;
            assign pop_req    = data_rd;
            assign core_rdata = '0;
        end else begin : g_tx
            logic unused_tx;
            assign unused_tx  = ^{core_push, core_wdata, data_rd};
            assign push_req   = data_wr;
            assign push_data  = reg_wdata[DW-1:0];
            assign pop_req    = core_pop;
            assign core_rdata = head_data;
        end
    endgenerate

    fifo_fill_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .pop_req(pop_req), .flush(flush_req),
        .thr_nxt(thr_nxt),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .level(fifo_level), .full(fifo_full), .empty(fifo_empty),
        .thr_flag(thr_flag)
    );

    fifo_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_ok), .wr_data(push_data),
        .rd_en(pop_ok), .flush(flush_req),
        .is_empty(fifo_empty), .head_data(head_data)
    );

endmodule

// File: rtl/fifo_port_chk.sv
`timescale 1ns/1ps
module fifo_port_chk #(
    parameter int AW = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        push_ok,
    input logic        pop_ok,
    input logic        flush,
    input logic [AW:0] level,
    input logic        full,
    input logic        empty,
    input logic [AW:0] thr_q,
    input logic        thr_flag
);
    localparam logic [AW:0] LVL_MAX = {1'b1, {AW{1'b0}}};

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && push_ok)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && pop_ok)); // R6
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        thr_flag == (level > thr_q)); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0) && empty); // R8
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok && !flush) |=> $stable(level)); // R9
    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0)); // R11
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level == LVL_MAX)); // R11

endmodule

bind bus_fifo_port fifo_port_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .push_ok(push_ok), .pop_ok(pop_ok), .flush(flush_req),
    .level(fifo_level), .full(fifo_full), .empty(fifo_empty),
    .thr_q(thr_q), .thr_flag(thr_flag)
);

// File: tb/bus_fifo_port_test.sv
`timescale 1ns/1ps
module bus_fifo_port_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    // transmit-build signals
    logic t_sel = 0, t_wr = 0, t_cpush = 0, t_cpop = 0;
    logic [15:0] t_addr = 0;
    logic [31:0] t_wdata = 0, t_rdata;
    logic [DW-1:0] t_cwdata = 0, t_crdata;
    logic [AW:0] t_lvl;
    logic t_full, t_empty, t_flag;

    // receive-build signals
    logic r_sel = 0, r_wr = 0, r_cpush = 0, r_cpop = 0;
    logic [15:0] r_addr = 0;
    logic [31:0] r_wdata = 0, r_rdata;
    logic [DW-1:0] r_cwdata = 0, r_crdata;
    logic [AW:0] r_lvl;
    logic r_full, r_empty, r_flag;

    bus_fifo_port #(.AW(AW), .DW(DW), .IS_RX(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(t_sel), .reg_wr(t_wr),
        .reg_addr(t_addr), .reg_wdata(t_wdata), .reg_rdata(t_rdata),
        .core_push(t_cpush), .core_wdata(t_cwdata), .core_pop(t_cpop),
        .core_rdata(t_crdata), .fifo_level(t_lvl), .fifo_full(t_full),
        .fifo_empty(t_empty), .thr_flag(t_flag));

    bus_fifo_port #(.AW(AW), .DW(DW), .IS_RX(1'b1)) uut_rx (
        .clk(clk), .rst_n(rst_n), .reg_sel(r_sel), .reg_wr(r_wr),
        .reg_addr(r_addr), .reg_wdata(r_wdata), .reg_rdata(r_rdata),
        .core_push(r_cpush), .core_wdata(r_cwdata), .core_pop(r_cpop),
        .core_rdata(r_crdata), .fifo_level(r_lvl), .fifo_full(r_full),
        .fifo_empty(r_empty), .thr_flag(r_flag));

    logic [DW-1:0] q_tx[$];
    logic [DW-1:0] q_rx[$];
    logic [DW-1:0] last_tx = '0;
    logic [DW-1:0] last_rx = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitors: compare popped words against the scoreboard before the edge
    always @(negedge clk) begin
        if (rst_n && t_cpop) begin
            if (q_tx.size() > 0) begin
                last_tx = q_tx.pop_front();
                chk("R2 tx pop order", {24'h0, t_crdata}, {24'h0, last_tx});
            end else begin
                chk("R6 tx pop empty", {24'h0, t_crdata}, {24'h0, last_tx});
            end
        end
        if (rst_n && r_sel && !r_wr && r_addr == 16'hFE00) begin
            if (q_rx.size() > 0) begin
                last_rx = q_rx.pop_front();
                chk("R3 rx read order", r_rdata, {24'h0, last_rx});
            end else begin
                chk("R6 rx read empty", r_rdata, {24'h0, last_rx});
            end
        end
    end

    // one transmit cycle: optional bus push, optional core pop
    task automatic tx_op(input bit push, input logic [DW-1:0] w, input bit pop);
        int n = q_tx.size();
        t_sel = push; t_wr = push; t_addr = 16'hFE00;
        t_wdata = {24'hC0FFEE, w}; t_cpop = pop;
        @(posedge clk);
        if (push && n < DEPTH) q_tx.push_back(w);
        #0.5;
        t_sel = 0; t_wr = 0; t_cpop = 0;
    endtask

    task automatic rx_op(input bit push, input logic [DW-1:0] w, input bit rd);
        int n = q_rx.size();
        r_cpush = push; r_cwdata = w; r_sel = rd; r_wr = 0; r_addr = 16'hFE00;
        @(posedge clk);
        if (push && n < DEPTH) q_rx.push_back(w);
        #0.5;
        r_cpush = 0; r_sel = 0;
    endtask

    task automatic tx_wr(input logic [15:0] a, input logic [31:0] d);
        t_sel = 1; t_wr = 1; t_addr = a; t_wdata = d;
        @(posedge clk); #0.5;
        t_sel = 0; t_wr = 0;
    endtask

    task automatic tx_peek(input logic [15:0] a, output logic [31:0] d);
        t_sel = 1; t_wr = 0; t_addr = a;
        #0.5; d = t_rdata;
        t_sel = 0;
    endtask

    task automatic rx_peek(input logic [15:0] a, output logic [31:0] d);
        r_sel = 1; r_wr = 0; r_addr = a;
        #0.5; d = r_rdata;
        r_sel = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(posedge clk); #0.5;

        // R1 reset state
        chk("R1 tx level", {27'h0, t_lvl}, 0);
        chk("R1 tx empty", {31'h0, t_empty}, 1);
        chk("R1 tx full", {31'h0, t_full}, 0);
        chk("R1 tx flag", {31'h0, t_flag}, 0);
        tx_peek(16'hFE08, rd); chk("R1 threshold", rd, 0);
        chk("R1 rx level", {27'h0, r_lvl}, 0);
        chk("R1 rx empty", {31'h0, r_empty}, 1);

        // R7 threshold load, only bits [AW:0] kept
        tx_wr(16'hFE08, 32'hFFFF_FFE3);
        tx_peek(16'hFE08, rd); chk("R7 threshold readback", rd, 3);

        // R2/R4/R7 fill five words
        for (int i = 0; i < 5; i++) begin
            tx_op(1, 8'h10 + 8'(i), 0);
            chk("R4 level port", {27'h0, t_lvl}, q_tx.size());
            chk("R7 flag vs level", {31'h0, t_flag}, (q_tx.size() > 3) ? 1 : 0);
        end
        tx_peek(16'hFE04, rd); chk("R4 level register", rd, 5);
        tx_peek(16'hFE00, rd); chk("R10 tx data readback", rd, 32'h14);

        // R10 ignored inputs in transmit build
        t_cpush = 1; t_cwdata = 8'h77;
        @(posedge clk); #0.5; t_cpush = 0;
        chk("R10 core_push ignored", {27'h0, t_lvl}, 5);
        t_sel = 1; t_wr = 0; t_addr = 16'hFE00;
        @(posedge clk); #0.5; t_sel = 0;
        chk("R10 bus read no pop", {27'h0, t_lvl}, 5);

        // R9 push and pop together
        tx_op(1, 8'h20, 1);
        chk("R9 level held", {27'h0, t_lvl}, 5);

        // R2/R6 drain and pop past empty
        for (int i = 0; i < 5; i++) tx_op(0, 0, 1);
        chk("R11 empty after drain", {31'h0, t_empty}, 1);
        tx_op(0, 0, 1);
        tx_op(0, 0, 1);
        chk("R6 level stays 0", {27'h0, t_lvl}, 0);

        // R5 fill to full, overflow dropped
        for (int i = 0; i < DEPTH; i++) tx_op(1, 8'h40 + 8'(i), 0);
        chk("R11 full flag", {31'h0, t_full}, 1);
        tx_op(1, 8'hEE, 0);
        chk("R5 level at max", {27'h0, t_lvl}, DEPTH);
        tx_peek(16'hFE04, rd); chk("R4 level full", rd, DEPTH);
        tx_op(1, 8'hDD, 1);
        chk("R5 push dropped with pop", {27'h0, t_lvl}, DEPTH - 1);
        for (int i = 0; i < DEPTH - 1; i++) tx_op(0, 0, 1);
        chk("R11 empty after full drain", {31'h0, t_empty}, 1);

        // R7 threshold change moves flag at same edge
        tx_op(1, 8'h51, 0); tx_op(1, 8'h52, 0);
        chk("R7 flag low at 2", {31'h0, t_flag}, 0);
        tx_wr(16'hFE08, 32'h1);
        chk("R7 flag on thr write", {31'h0, t_flag}, 1);

        // R8 flush
        tx_op(1, 8'h53, 0);
        tx_wr(16'hFE0C, 32'h0000_1234);
        q_tx.delete();
        chk("R8 level after flush", {27'h0, t_lvl}, 0);
        chk("R8 empty after flush", {31'h0, t_empty}, 1);
        chk("R8 flag after flush", {31'h0, t_flag}, 0);
        tx_peek(16'hFE0C, rd); chk("R8 flush reads 0", rd, 0);
        tx_op(1, 8'h61, 0); tx_op(1, 8'h62, 0);
        tx_op(0, 0, 1); tx_op(0, 0, 1);

        // R12 unmapped
        tx_op(1, 8'h70, 0);
        tx_wr(16'hFE10, 32'hFFFF_FFFF);
        tx_wr(16'h1E04, 32'hFFFF_FFFF);
        chk("R12 unmapped write", {27'h0, t_lvl}, 1);
        tx_peek(16'hFE10, rd); chk("R12 unmapped read", rd, 0);
        tx_peek(16'hFE08, rd); chk("R12 threshold untouched", rd, 1);
        tx_op(0, 0, 1);

        // R3 receive build
        for (int i = 0; i < 4; i++) rx_op(1, 8'hA0 + 8'(i), 0);
        chk("R3 rx level", {27'h0, r_lvl}, 4);
        rx_peek(16'hFE04, rd); chk("R4 rx level register", rd, 4);
        rx_op(1, 8'hA4, 1);
        chk("R9 rx level held", {27'h0, r_lvl}, 4);
        r_cpop = 1; @(posedge clk); #0.5; r_cpop = 0;
        chk("R10 rx core_pop ignored", {27'h0, r_lvl}, 4);
        r_sel = 1; r_wr = 1; r_addr = 16'hFE00; r_wdata = 32'h99;
        @(posedge clk); #0.5; r_sel = 0; r_wr = 0;
        chk("R10 rx bus write ignored", {27'h0, r_lvl}, 4);
        for (int i = 0; i < 4; i++) rx_op(0, 0, 1);
        rx_op(0, 0, 1);
        chk("R6 rx level 0", {27'h0, r_lvl}, 0);

        // R8 flush overrides simultaneous core push
        rx_op(1, 8'hB0, 0);
        r_sel = 1; r_wr = 1; r_addr = 16'hFE0C; r_wdata = 32'h5; r_cpush = 1; r_cwdata = 8'hB1;
        @(posedge clk); #0.5;
        r_sel = 0; r_wr = 0; r_cpush = 0;
        q_rx.delete();
        chk("R8 rx flush wins", {27'h0, r_lvl}, 0);
        rx_op(1, 8'hC1, 0);
        rx_op(0, 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule